// File: doc/BRIEF.md
# Q15 Fractional Multiply-Accumulate Unit

This block multiplies two signed 16-bit fractions in Q15 form, where bit 15 is the sign and bits 14..0 are the fraction. Each operand pair takes one clock. The raw two's-complement product carries a duplicated sign bit. The block removes that bit by shifting the product left once, which gives a Q31 value. A 2-bit mode then decides what happens to the Q31 product. It can replace the accumulator, be added to it, or be subtracted from it.

Results never wrap. A product or an accumulator sum that falls outside the 32-bit signed range is clamped to the nearest limit, and a sticky overflow flag is raised. Alongside the full Q31 accumulator, the block presents a 16-bit Q15 result. That result is the upper half of the accumulator after round-to-nearest, and it is also clamped. A clear input empties the accumulator. The clear can be combined with a valid operand pair, so that a new sum of products starts in the same cycle as the clear.

Top module: `q15_mac`

## Requirements
- R1: While `rst` is high at a rising edge, the next state is `acc_q31`=0, `res_q15`=0 and `ovf`=0. Reset is synchronous and active-high.
- R2: With `in_valid`=1 and `mode`=2'b00, the accumulator takes the Q31 product (signed `op_a`×`op_b` shifted left by one), and its previous value is discarded. Code 2'b11 behaves the same way.
- R3: With `in_valid`=1 and `mode`=2'b01, the Q31 product is added to the accumulator.
- R4: With `in_valid`=1 and `mode`=2'b10, the Q31 product is subtracted from the accumulator.
- R5: The product 0x8000×0x8000 (−1×−1) is clamped to 0x7FFF_FFFF, and `ovf` is set.
- R6: An add or subtract result above 0x7FFF_FFFF becomes 0x7FFF_FFFF. A result below −2^31 becomes 0x8000_0000. In both cases `ovf` is set.
- R7: `res_q15` is bits 31..16 of (accumulator + 0x0000_8000). A tie rounds upward. If the addition passes the positive limit, the result is 0x7FFF.
- R8: Once set, `ovf` stays at 1 through later operations, in every mode, until a clear or a reset.
- R9: `acc_clr`=1 with `in_valid`=0 sets the accumulator, `res_q15` and `ovf` to zero.
- R10: `acc_clr`=1 together with `in_valid`=1 applies the selected mode to a zero accumulator. In that case `ovf` reflects only this operation.
- R11: With `in_valid`=0 and `acc_clr`=0, the accumulator, `res_q15` and `ovf` hold, whatever `op_a`, `op_b` and `mode` do.
- R12: An operation accepted at a rising edge is visible on all three outputs immediately after that edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand pair present this cycle |
| op_a | input | 16 | Q15 multiplicand |
| op_b | input | 16 | Q15 multiplier |
| mode | input | 2 | 00/11 multiply, 01 multiply-add, 10 multiply-subtract |
| acc_clr | input | 1 | Empty the accumulator and clear the overflow flag |
| acc_q31 | output | 32 | Q31 accumulator |
| res_q15 | output | 16 | Rounded and clamped Q15 result |
| ovf | output | 1 | Sticky overflow flag |

## Verification
Two functions can fall in the same cycle: a clear and an accepted operand pair. The bench first drives the accumulator into negative saturation, so that the overflow flag is set. It then raises `acc_clr` and `in_valid` in one cycle, using multiply-subtract. The result is judged correct only when the accumulator holds exactly the negated product and the flag has dropped. A second coincidence is also driven. The −1×−1 product saturates, and the rounding that follows must also clamp, to 0x7FFF.

// File: rtl/q15_mac.sv
module q15_mac #(
  parameter int W = 16
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           in_valid,
  input  logic [W-1:0]   op_a,
  input  logic [W-1:0]   op_b,
  input  logic [1:0]     mode,
  input  logic           acc_clr,
  output logic [2*W-1:0] acc_q31,
  output logic [W-1:0]   res_q15,
  output logic           ovf
);
  localparam int PW = 2 * W;
  localparam logic [PW-1:0] MAXV = {1'b0, {(PW-1){1'b1}}};
  localparam logic [PW-1:0] MINV = {1'b1, {(PW-1){1'b0}}};
  localparam logic [PW-1:0] HALF = {{W{1'b0}}, 1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0]  NEG1 = {1'b1, {(W-1){1'b0}}};
  localparam logic [W-1:0]  QMAX = {1'b0, {(W-1){1'b1}}};

  logic signed [PW-1:0] prod_raw;
  logic [PW-1:0] prod_q, base, acc_nx, rnd;
  logic [PW+1:0] sum;
  logic prod_ovf, sum_ovf, rnd_ovf;
  logic [W-1:0] res_nx;

  assign prod_raw = $signed(op_a) * $signed(op_b);
  assign prod_ovf = (op_a == NEG1) && (op_b == NEG1);
  assign prod_q   = prod_ovf ? MAXV : PW'(prod_raw <<< 1);
  assign base     = acc_clr ? '0 : acc_q31;

  always_comb begin
    case (mode)
      2'b01:   sum = {{2{base[PW-1]}}, base} + {{2{prod_q[PW-1]}}, prod_q};
      2'b10:   sum = {{2{base[PW-1]}}, base} - {{2{prod_q[PW-1]}}, prod_q};
      default: sum = {{2{prod_q[PW-1]}}, prod_q};
    endcase
  end

  assign sum_ovf = !((sum[PW+1:PW-1] == 3'b000) || (sum[PW+1:PW-1] == 3'b111));
  assign acc_nx  = sum_ovf ? (sum[PW+1] ? MINV : MAXV) : sum[PW-1:0];

  assign rnd     = acc_nx + HALF;
  assign rnd_ovf = !acc_nx[PW-1] && rnd[PW-1];
  assign res_nx  = rnd_ovf ? QMAX : rnd[PW-1:W];

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q31 <= '0;
      res_q15 <= '0;
      ovf     <= 1'b0;
    end else if (in_valid) begin
      acc_q31 <= acc_nx;
      res_q15 <= res_nx;
      ovf     <= (ovf && !acc_clr) || prod_ovf || sum_ovf;
    end else if (acc_clr) begin
      acc_q31 <= '0;
      res_q15 <= '0;
      ovf     <= 1'b0;
    end
  end
endmodule

// File: rtl/q15_mac_chk.sv
module q15_mac_chk #(
  parameter int W = 16
) (
  input logic           clk,
  input logic           rst,
  input logic           in_valid,
  input logic [W-1:0]   op_a,
  input logic [W-1:0]   op_b,
  input logic [1:0]     mode,
  input logic           acc_clr,
  input logic [2*W-1:0] acc_q31,
  input logic [W-1:0]   res_q15,
  input logic           ovf
);
  // R1
  reset_zero_chk: assert property (@(posedge clk)
    rst |=> (acc_q31 == '0 && res_q15 == '0 && !ovf));

  // R8
  sticky_ovf_chk: assert property (@(posedge clk) disable iff (rst)
    (ovf && !acc_clr) |=> ovf);

  // R9
  clear_only_chk: assert property (@(posedge clk) disable iff (rst)
    (acc_clr && !in_valid) |=> (acc_q31 == '0 && res_q15 == '0 && !ovf));

  // R11
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!in_valid && !acc_clr) |=> ($stable(acc_q31) && $stable(res_q15) && $stable(ovf)));

  // R5
  min_square_chk: assert property (@(posedge clk) disable iff (rst)
    (in_valid && mode == 2'b00 && op_a == {1'b1, {(W-1){1'b0}}} && op_b == {1'b1, {(W-1){1'b0}}})
    |=> (acc_q31 == {1'b0, {(2*W-1){1'b1}}} && ovf));
endmodule

bind q15_mac q15_mac_chk #(.W(W)) chk_i (
  .clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
  .mode(mode), .acc_clr(acc_clr), .acc_q31(acc_q31), .res_q15(res_q15), .ovf(ovf)
);

// File: tb/q15_mac_test.sv
module q15_mac_test;
  logic clk = 1'b0, rst = 1'b1, in_valid = 1'b0, acc_clr = 1'b0;
  logic [15:0] op_a = '0, op_b = '0;
  logic [1:0] mode = '0;
  logic [31:0] acc_q31;
  logic [15:0] res_q15;
  logic ovf;
  int errors = 0, checks = 0;
  bit done = 0;

  q15_mac uut (.clk(clk), .rst(rst), .in_valid(in_valid), .op_a(op_a), .op_b(op_b),
               .mode(mode), .acc_clr(acc_clr), .acc_q31(acc_q31), .res_q15(res_q15), .ovf(ovf));

  always #2 clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, got, exp);
    end
  endtask

  task automatic expect_all(input string req, input logic [31:0] a, input logic [15:0] r, input logic o);
    chk({req, " acc"}, acc_q31, a);
    chk({req, " res"}, {16'h0, res_q15}, {16'h0, r});
    chk({req, " ovf"}, {31'h0, ovf}, {31'h0, o});
  endtask

  task automatic step(input logic v, input logic c, input logic [1:0] m,
                      input logic [15:0] a, input logic [15:0] b);
    @(negedge clk);
    in_valid = v; acc_clr = c; mode = m; op_a = a; op_b = b;
    @(posedge clk); #1;
    in_valid = 1'b0; acc_clr = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    @(posedge clk); #1;
    expect_all("R1 reset", 32'h0, 16'h0, 1'b0);
    @(negedge clk); rst = 1'b0;
  endtask

  task automatic t_modes;
    step(1, 0, 2'b00, 16'h4000, 16'h4000);
    expect_all("R2 R12 mul", 32'h2000_0000, 16'h2000, 1'b0);
    step(1, 0, 2'b01, 16'h4000, 16'h4000);
    expect_all("R3 mac", 32'h4000_0000, 16'h4000, 1'b0);
    step(1, 0, 2'b10, 16'h2000, 16'h4000);
    expect_all("R4 msu", 32'h3000_0000, 16'h3000, 1'b0);
    step(1, 0, 2'b11, 16'h8000, 16'h4000);
    expect_all("R2 mode11 neg", 32'hC000_0000, 16'hC000, 1'b0);
  endtask

  task automatic t_min_square;
    step(1, 0, 2'b00, 16'h8000, 16'h8000);
    expect_all("R5 R7 min square", 32'h7FFF_FFFF, 16'h7FFF, 1'b1);
    step(1, 0, 2'b00, 16'h4000, 16'h4000);
    expect_all("R8 sticky", 32'h2000_0000, 16'h2000, 1'b1);
    step(0, 1, 2'b00, 16'h1234, 16'h5678);
    expect_all("R9 clear", 32'h0, 16'h0, 1'b0);
  endtask

  task automatic t_clamp;
    step(1, 0, 2'b00, 16'h7FFF, 16'h7FFF);
    expect_all("R2 max square", 32'h7FFE_0002, 16'h7FFE, 1'b0);
    step(1, 0, 2'b01, 16'h7FFF, 16'h7FFF);
    expect_all("R6 pos clamp", 32'h7FFF_FFFF, 16'h7FFF, 1'b1);
    step(1, 1, 2'b00, 16'h8000, 16'h7FFF);
    expect_all("R10 clr+mul", 32'h8001_0000, 16'h8001, 1'b0);
    step(1, 0, 2'b01, 16'h8000, 16'h7FFF);
    expect_all("R6 neg clamp", 32'h8000_0000, 16'h8000, 1'b1);
    step(1, 1, 2'b10, 16'h4000, 16'h4000);
    expect_all("R10 clr+msu", 32'hE000_0000, 16'hE000, 1'b0);
  endtask

  task automatic t_round;
    step(1, 0, 2'b00, 16'h00C0, 16'h0100);
    expect_all("R7 round up", 32'h0001_8000, 16'h0002, 1'b0);
    step(1, 0, 2'b00, 16'h0040, 16'h0100);
    expect_all("R7 tie", 32'h0000_8000, 16'h0001, 1'b0);
    step(1, 0, 2'b00, 16'h0030, 16'h0100);
    expect_all("R7 round down", 32'h0000_6000, 16'h0000, 1'b0);
    step(1, 0, 2'b00, 16'hFF40, 16'h0100);
    expect_all("R7 negative", 32'hFFFE_8000, 16'hFFFF, 1'b0);
  endtask

  task automatic t_hold;
    step(1, 0, 2'b00, 16'h8000, 16'h8000);
    for (int i = 0; i < 4; i++) begin
      step(0, 0, 2'(i), 16'h1111 * 16'(i + 1), 16'h7000);
    end
    expect_all("R11 hold", 32'h7FFF_FFFF, 16'h7FFF, 1'b1);
    @(negedge clk); rst = 1'b1;
    @(posedge clk); #1;
    expect_all("R1 mid reset", 32'h0, 16'h0, 1'b0);
    @(negedge clk); rst = 1'b0;
  endtask

  initial begin
    t_reset();
    t_modes();
    t_min_square();
    t_clamp();
    t_round();
    t_hold();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #400000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule